// File: doc/BRIEF.md
# Row and Diagonal Dual-Parity Stripe Encoder

This block builds the two redundancy columns of a storage stripe. The stripe is a grid of data words: `ROWS` rows of `DCOLS` data columns. The encoder keeps two kinds of parity. The first is a horizontal parity per row. The second is a parity along wrapped diagonals, taken over the data columns and the horizontal-parity column together. With a prime diagonal count, any two lost columns can later be rebuilt. Data words enter one cell at a time. Each word either carries an explicit row/column tag or follows an internal row-major pointer.

Once every cell of the stripe holds a word, the block raises `stripe_full` so the surrounding logic may commit the stripe. From the next cycle it streams out the parity words: first every row word, then every diagonal word. While a stripe is draining, input is refused. After the final parity word is taken, all state is cleared and the next stripe begins.

Both edges are valid/ready streams. A word moves only in a cycle where valid and ready are both high. On the output side, a stalled word (`out_valid` high, `out_ready` low) keeps its data, kind and last flag until it is taken. On the input side, `in_ready` is low for the whole time `stripe_full` is high.

Top module: `dpar_encoder`

## Requirements
- R1: After reset the block has `in_ready`=1, `stripe_full`=0, `out_valid`=0 and `cell_err`=0.
- R2: The row word for row r is the XOR of the data words in row r across columns 0..DCOLS-1.
- R3: Diagonal word d is the XOR of every cell (r,c) with (r+c) mod NDIAG = d. Here c runs over the data columns 0..DCOLS-1 plus the row-parity column, which is counted as column DCOLS and holds the row words.
- R4: When `in_tagged`=1, the word goes to cell (`in_row`,`in_col`). When `in_tagged`=0, it goes to the cell named by an internal pointer. The pointer starts at (0,0) for each stripe and advances after every accepted untagged word: along the columns of a row, then to column 0 of the next row, and from (ROWS-1,DCOLS-1) back to (0,0).
- R5: If an accepted word targets a cell already filled in the current stripe, `cell_err` is high for exactly the following cycle. The word is not folded into any parity and does not count toward filling the stripe.
- R6: If an accepted tagged word has `in_row`>=ROWS or `in_col`>=DCOLS, it raises `cell_err` in the following cycle and is otherwise ignored.
- R7: `stripe_full` rises in the cycle after the last empty cell is filled. While it is high, `in_ready` is 0. `out_valid` first rises one cycle after `stripe_full`.
- R8: Each stripe emits ROWS+NDIAG words. The first ROWS words are the row words in row order, with `out_diag`=0. The rest are the diagonal words in index order, with `out_diag`=1. `out_last` is 1 only on the final word.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_diag` and `out_last` hold their values.
- R10: In the cycle after the final word is taken, `stripe_full` and `out_valid` are 0 and `in_ready` is 1. The next stripe's parity depends only on that stripe's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block accepts input this cycle |
| in_tagged | input | 1 | 1: use `in_row`/`in_col`; 0: use the internal pointer |
| in_row | input | $clog2(ROWS+1) | Row tag |
| in_col | input | $clog2(DCOLS+1) | Column tag |
| in_data | input | W | Data word |
| cell_err | output | 1 | One-cycle pulse: the previous accepted word was a duplicate or out of range |
| stripe_full | output | 1 | The stripe is complete and its parity is draining |
| out_valid | output | 1 | A parity word is offered |
| out_ready | input | 1 | Downstream takes the parity word |
| out_data | output | W | Parity word |
| out_diag | output | 1 | 0: row word, 1: diagonal word |
| out_last | output | 1 | Final parity word of the stripe |

## Verification
The checks assume that `out_ready` may drop at any cycle. They also assume that stimulus never needs a word to be taken while `in_ready` is low, because such a word is simply not taken. The bench deliberately holds `in_valid` high during the drain to show that those words are dropped, and it stalls the output at random. The checks also assume that reset is released on a clock-aligned edge. The stimulus covers streaming, shuffled tagged order and a mix of the two. It injects repeated cells and out-of-range tags mid-stripe, so that the error pulse and the pointer behaviour are exercised within the rules above.

// File: rtl/dpar_pkg.sv
package dpar_pkg;

  typedef enum logic [1:0] {
    PH_FILL,
    PH_HOLD,
    PH_SEND
  } phase_e;

  // Wrapped diagonal index of a cell.
  function automatic int unsigned diag_of(input int unsigned r,
                                          input int unsigned c,
                                          input int unsigned nd);
    return (r + c) % nd;
  endfunction

endpackage

// File: rtl/dpar_ingress.sv
module dpar_ingress #(
  parameter int ROWS  = 28,
  parameter int DCOLS = 23,
  parameter int RW    = 5,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accepting,
  input  logic          clear,
  input  logic          in_valid,
  input  logic          in_tagged,
  input  logic [RW-1:0] in_row,
  input  logic [CW-1:0] in_col,
  output logic          in_ready,
  output logic          wr_en,
  output logic [RW-1:0] wr_row,
  output logic [CW-1:0] wr_col,
  output logic          cell_err,
  output logic          fill_done
);
  localparam int CELLS = ROWS * DCOLS;
  localparam int NW    = $clog2(CELLS + 1);
  localparam logic [RW-1:0] ROW_LIM  = RW'(ROWS);
  localparam logic [CW-1:0] COL_LIM  = CW'(DCOLS);
  localparam logic [RW-1:0] ROW_END  = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_END  = CW'(DCOLS - 1);
  localparam logic [NW-1:0] CNT_LAST = NW'(CELLS - 1);

  logic [ROWS-1:0][DCOLS-1:0] filled_q;
  logic [NW-1:0] count_q;
  logic [RW-1:0] ptr_row_q;
  logic [CW-1:0] ptr_col_q;
  logic          err_q;

  logic          fire, in_range, good;
  logic [RW-1:0] sel_row, r_ix;
  logic [CW-1:0] sel_col, c_ix;

  always_comb begin
    fire     = in_valid && accepting;
    sel_row  = in_tagged ? in_row : ptr_row_q;
    sel_col  = in_tagged ? in_col : ptr_col_q;
    in_range = (sel_row < ROW_LIM) && (sel_col < COL_LIM);
    r_ix     = in_range ? sel_row : '0;
    c_ix     = in_range ? sel_col : '0;
    good     = fire && in_range && !filled_q[r_ix][c_ix];
  end

  assign in_ready  = accepting;
  assign wr_en     = good;
  assign wr_row    = r_ix;
  assign wr_col    = c_ix;
  assign fill_done = good && (count_q == CNT_LAST);
  assign cell_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled_q  <= '0;
      count_q   <= '0;
      ptr_row_q <= '0;
      ptr_col_q <= '0;
      err_q     <= 1'b0;
    end else if (clear) begin
      filled_q  <= '0;
      count_q   <= '0;
      ptr_row_q <= '0;
      ptr_col_q <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= fire && !good;
      if (good) begin
        filled_q[r_ix][c_ix] <= 1'b1;
        count_q              <= count_q + 1'b1;
      end
      if (fire && !in_tagged) begin
        if (ptr_col_q == COL_END) begin
          ptr_col_q <= '0;
          ptr_row_q <= (ptr_row_q == ROW_END) ? '0 : ptr_row_q + 1'b1;
        end else begin
          ptr_col_q <= ptr_col_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dpar_accum.sv
module dpar_accum #(
  parameter int W     = 32,
  parameter int ROWS  = 28,
  parameter int DCOLS = 23,
  parameter int NDIAG = 29,
  parameter int RW    = 5,
  parameter int CW    = 5,
  parameter int OW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_row,
  input  logic [CW-1:0] wr_col,
  input  logic [W-1:0]  wr_data,
  input  logic [OW-1:0] rd_sel,
  output logic [W-1:0]  rd_data
);
  localparam int DW = $clog2(NDIAG);

  logic [W-1:0]  row_q  [ROWS];
  logic [W-1:0]  diag_q [NDIAG];
  logic [DW-1:0] diag_cell, diag_rowpar;

  // A data word feeds its own diagonal and, through its row word,
  // the diagonal of the row-parity column.
  always_comb begin
    diag_cell   = DW'(dpar_pkg::diag_of(32'(wr_row), 32'(wr_col), NDIAG));
    diag_rowpar = DW'(dpar_pkg::diag_of(32'(wr_row), DCOLS, NDIAG));
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                row_q[i] <= '0;
      else if (clear)                            row_q[i] <= '0;
      else if (wr_en && (wr_row == RW'(i)))      row_q[i] <= row_q[i] ^ wr_data;
    end
  end

  for (genvar j = 0; j < NDIAG; j++) begin : g_diag
    logic hit;
    assign hit = wr_en && ((diag_cell == DW'(j)) || (diag_rowpar == DW'(j)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      diag_q[j] <= '0;
      else if (clear)  diag_q[j] <= '0;
      else if (hit)    diag_q[j] <= diag_q[j] ^ wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < ROWS; k++)
      if (rd_sel == OW'(k)) rd_data = row_q[k];
    for (int k = 0; k < NDIAG; k++)
      if (rd_sel == OW'(ROWS + k)) rd_data = diag_q[k];
  end

endmodule

// File: rtl/dpar_egress.sv
module dpar_egress #(
  parameter int ROWS  = 28,
  parameter int NDIAG = 29,
  parameter int OW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_done,
  input  logic          out_ready,
  output logic          accepting,
  output logic          stripe_full,
  output logic          out_valid,
  output logic          out_last,
  output logic          out_diag,
  output logic [OW-1:0] rd_sel,
  output logic          clear
);
  import dpar_pkg::*;

  localparam logic [OW-1:0] IDX_LAST = OW'(ROWS + NDIAG - 1);
  localparam logic [OW-1:0] IDX_DIAG = OW'(ROWS);

  phase_e        ph_q;
  logic [OW-1:0] idx_q;

  assign accepting   = (ph_q == PH_FILL);
  assign stripe_full = (ph_q != PH_FILL);
  assign out_valid   = (ph_q == PH_SEND);
  assign rd_sel      = idx_q;
  assign out_last    = out_valid && (idx_q == IDX_LAST);
  assign out_diag    = (idx_q >= IDX_DIAG);
  assign clear       = out_valid && out_ready && (idx_q == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_FILL;
      idx_q <= '0;
    end else begin
      unique case (ph_q)
        PH_FILL: if (fill_done) ph_q <= PH_HOLD;
        PH_HOLD: begin
          ph_q  <= PH_SEND;
          idx_q <= '0;
        end
        PH_SEND: if (out_ready) begin
          if (idx_q == IDX_LAST) begin
            ph_q  <= PH_FILL;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: ph_q <= PH_FILL;
      endcase
    end
  end

endmodule

// File: rtl/dpar_encoder.sv
module dpar_encoder #(
  parameter int W     = 32,
  parameter int DCOLS = 23,
  parameter int ROWS  = 28,
  parameter int NDIAG = 29
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_tagged,
  input  logic [$clog2(ROWS+1)-1:0]  in_row,
  input  logic [$clog2(DCOLS+1)-1:0] in_col,
  input  logic [W-1:0]               in_data,
  output logic                       cell_err,
  output logic                       stripe_full,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [W-1:0]               out_data,
  output logic                       out_diag,
  output logic                       out_last
);
  localparam int RW = $clog2(ROWS + 1);
  localparam int CW = $clog2(DCOLS + 1);
  localparam int OW = $clog2(ROWS + NDIAG);

  logic          accepting, clear, wr_en, fill_done;
  logic [RW-1:0] wr_row;
  logic [CW-1:0] wr_col;
  logic [OW-1:0] rd_sel;

  dpar_ingress #(.ROWS(ROWS), .DCOLS(DCOLS), .RW(RW), .CW(CW)) u_ingress (
    .clk       (clk),
    .rst_n     (rst_n),
    .accepting (accepting),
    .clear     (clear),
    .in_valid  (in_valid),
    .in_tagged (in_tagged),
    .in_row    (in_row),
    .in_col    (in_col),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_col    (wr_col),
    .cell_err  (cell_err),
    .fill_done (fill_done)
  );

  dpar_accum #(.W(W), .ROWS(ROWS), .DCOLS(DCOLS), .NDIAG(NDIAG),
               .RW(RW), .CW(CW), .OW(OW)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_col  (wr_col),
    .wr_data (in_data),
    .rd_sel  (rd_sel),
    .rd_data (out_data)
  );

  dpar_egress #(.ROWS(ROWS), .NDIAG(NDIAG), .OW(OW)) u_egress (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_done   (fill_done),
    .out_ready   (out_ready),
    .accepting   (accepting),
    .stripe_full (stripe_full),
    .out_valid   (out_valid),
    .out_last    (out_last),
    .out_diag    (out_diag),
    .rd_sel      (rd_sel),
    .clear       (clear)
  );

endmodule

// File: rtl/dpar_encoder_chk.sv
module dpar_encoder_chk #(
  parameter int W     = 32,
  parameter int ROWS  = 28,
  parameter int NDIAG = 29
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         cell_err,
  input logic         stripe_full,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_diag,
  input logic         out_last
);
  localparam int OW = $clog2(ROWS + NDIAG);
  localparam logic [OW-1:0] HS_LAST = OW'(ROWS + NDIAG - 1);
  localparam logic [OW-1:0] HS_DIAG = OW'(ROWS);

  logic [OW-1:0] hs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_cnt <= '0;
    else if (out_valid && out_ready) hs_cnt <= out_last ? '0 : hs_cnt + 1'b1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_diag) && $stable(out_last)); // R9
  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    stripe_full |-> !in_ready); // R7
  AST_VALID_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> stripe_full); // R7
  AST_FULL_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(stripe_full)); // R7
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cell_err |-> $past(in_valid && in_ready)); // R5
  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (hs_cnt == HS_LAST))); // R8
  AST_KIND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_diag == (hs_cnt >= HS_DIAG))); // R8
  AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !stripe_full && !out_valid && in_ready); // R10

endmodule

bind dpar_encoder dpar_encoder_chk #(.W(W), .ROWS(ROWS), .NDIAG(NDIAG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .cell_err    (cell_err),
  .stripe_full (stripe_full),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_diag    (out_diag),
  .out_last    (out_last)
);

// File: tb/dpar_encoder_tb.sv
`timescale 1ns/1ps
module dpar_encoder_tb;
  localparam int W = 32, DC = 23, NR = 28, ND = 29;
  localparam int CELLS = NR * DC;
  localparam int NOUT = NR + ND;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_tagged = 1'b0, out_ready = 1'b1;
  logic [4:0] in_row = '0, in_col = '0;
  logic [W-1:0] in_data = '0;
  logic in_ready, cell_err, stripe_full, out_valid, out_diag, out_last;
  logic [W-1:0] out_data;

  always #4 clk = ~clk;

  dpar_encoder #(.W(W), .DCOLS(DC), .ROWS(NR), .NDIAG(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tagged(in_tagged), .in_row(in_row), .in_col(in_col), .in_data(in_data),
    .cell_err(cell_err), .stripe_full(stripe_full), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_diag(out_diag), .out_last(out_last)
  );

  int n_chk = 0, n_err = 0, cyc = 0, err_seen = 0;
  string ctx = "R4 stream";
  bit stall_on = 1'b0, cmp_on = 1'b0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s (%s) actual=%0h expected=%0h at cycle %0d", req, ctx, act, exp, cyc);
    end
  endtask

  // Reference model
  logic [W-1:0] m_cell [NR][DC];
  bit           m_fill [NR][DC];
  logic [W-1:0] m_row [NR];
  logic [W-1:0] m_diag [ND];
  int m_phase = 0, m_idx = 0, m_cnt = 0, m_pr = 0, m_pc = 0;
  bit m_err = 0, m_stall_prev = 0, m_clr_prev = 0;

  task automatic m_clear();
    for (int r = 0; r < NR; r++) for (int c = 0; c < DC; c++) m_fill[r][c] = 0;
    m_cnt = 0; m_pr = 0; m_pc = 0;
  endtask

  task automatic m_parity();
    for (int r = 0; r < NR; r++) begin
      m_row[r] = '0;
      for (int c = 0; c < DC; c++) m_row[r] ^= m_cell[r][c];
    end
    for (int d = 0; d < ND; d++) m_diag[d] = '0;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c <= DC; c++)
        m_diag[(r + c) % ND] ^= (c < DC) ? m_cell[r][c] : m_row[r];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_idx = 0; m_err = 0; m_stall_prev = 0; m_clr_prev = 0;
      m_clear();
    end else begin
      bit e;
      e = 0;
      m_stall_prev = (m_phase == 2) && !out_ready;
      m_clr_prev = 0;
      case (m_phase)
        0: if (in_valid) begin
          int r, c;
          r = in_tagged ? int'(in_row) : m_pr;
          c = in_tagged ? int'(in_col) : m_pc;
          if (r < NR && c < DC && !m_fill[r][c]) begin
            m_fill[r][c] = 1; m_cell[r][c] = in_data; m_cnt++;
            if (m_cnt == CELLS) begin m_parity(); m_phase = 1; end
          end else e = 1;
          if (!in_tagged) begin
            if (m_pc == DC - 1) begin m_pc = 0; m_pr = (m_pr == NR - 1) ? 0 : m_pr + 1; end
            else m_pc++;
          end
        end
        1: begin m_phase = 2; m_idx = 0; end
        default: if (out_ready) begin
          if (m_idx == NOUT - 1) begin m_phase = 0; m_clear(); m_clr_prev = 1; end
          else m_idx++;
        end
      endcase
      m_err = e;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && cmp_on) begin
      if (cell_err === 1'b1) err_seen++;
      chk(m_clr_prev ? "R10 in_ready" : "R7 in_ready", in_ready, m_phase == 0);
      chk(m_clr_prev ? "R10 stripe_full" : "R7 stripe_full", stripe_full, m_phase != 0);
      chk("R7 out_valid", out_valid, m_phase == 2);
      chk("R5 cell_err", cell_err, m_err);
      if (m_phase == 2) begin
        chk(m_stall_prev ? "R9 out_data held" : (m_idx < NR ? "R2 row word" : "R3 diag word"),
            out_data, m_idx < NR ? m_row[m_idx] : m_diag[m_idx - NR]);
        chk("R8 out_diag", out_diag, m_idx >= NR);
        chk("R8 out_last", out_last, m_idx == NOUT - 1);
      end
    end
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R8 actual=%0d expected<%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  always @(negedge clk) out_ready <= stall_on ? ($urandom % 3 != 0) : 1'b1;

  task automatic send(input bit tg, input int r, input int c, input logic [W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_tagged = tg; in_row = 5'(r); in_col = 5'(c); in_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    idle();
    while (m_phase == 0) @(negedge clk);
    while (m_phase != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in_ready", in_ready, 1'b1);
    chk("R1 stripe_full", stripe_full, 1'b0);
    chk("R1 out_valid", out_valid, 1'b0);
    chk("R1 cell_err", cell_err, 1'b0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // Stripe A: pure row-major streaming, no back-pressure
    ctx = "R4 stream";
    for (int k = 0; k < CELLS; k++) send(0, 0, 0, $urandom);
    drain();

    // Stripe B: shuffled tagged order, repeats, bad tags, stalls
    ctx = "R4 tagged";
    stall_on = 1'b1;
    err_seen = 0;
    for (int k = 0; k < CELLS; k++) begin
      int p;
      p = (k * 135) % CELLS;
      if (k == CELLS - 1) begin
        send(1, 30, 3, $urandom);                  // R6 bad row
        send(1, 2, 25, $urandom);                  // R6 bad column
        send(1, (k * 135 % CELLS) / DC, 0, 32'hDEAD_BEEF);
      end
      send(1, p / DC, p % DC, $urandom);
      if (k == 100) send(1, p / DC, p % DC, 32'h1234_5678);  // R5 repeat
      if ($urandom % 4 == 0) idle();
    end
    send(1, 0, 0, 32'hFFFF_0000);                  // R7 ignored while full
    send(1, 1, 1, 32'h0000_FFFF);
    drain();
    ctx = "R5 R6 error count";
    chk("R6 and R5 error pulses", err_seen, 4);

    // Stripe C: tagged cell first, then streaming which meets it again
    ctx = "R4 mixed";
    stall_on = 1'b0;
    err_seen = 0;
    send(1, 0, 5, 32'hA5A5_A5A5);
    for (int k = 0; k < CELLS; k++) send(0, 0, 0, $urandom);
    drain();
    chk("R5 streamed repeat", err_seen, 1);
    chk("R10 idle after stripe", in_ready, 1'b1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule